// File: doc/BRIEF.md
# MIDI UART Host Port Controller

This block is a host-side MIDI interface that works only in plain UART mode. A host sees a window of two byte-wide addresses starting at a configurable base. The lower address is the data port. Writes there queue bytes for the serial output, and reads there return received bytes. The upper address is the command/status port. Reads there return two FIFO flags, and writes there are treated as commands.

Outgoing bytes pass through a 16-entry transmit FIFO into a serial transmitter. Incoming frames are collected by a receiver that runs 16 sample periods per bit, and the bytes land in a 16-entry receive FIFO. A receive interrupt follows the receive FIFO fill level against one of four thresholds, which a two-bit configuration input selects. The command FFh returns the whole interface to its power-up condition.

Top module: `midi_host_port`

## Requirements
- R1: The data port is at address `cfg_base` and the command/status port is at `cfg_base+1`. A read or write at any other address changes no state, and a read there returns 00h.
- R2: Each write to the data port is appended to a 16-entry transmit FIFO. Whenever that FIFO is not empty, bytes are sent in order on `midi_out` as frames of one low start bit, 8 data bits LSB first, and one high stop bit. Each bit lasts 16×`SAMPLE_DIV` clocks, and the line rests high. A write that arrives while the FIFO is full is dropped.
- R3: Valid received frames are stored in a 16-entry receive FIFO. A data-port read returns the oldest byte and removes it. A read of an empty receive FIFO returns 00h.
- R4: In the status byte, bit 7 is 1 when the receive FIFO is empty and 0 otherwise, bit 6 is 1 when the transmit FIFO is full, and bits 5..0 are 0.
- R5: `rx_irq` is high exactly while the receive FIFO count is at least the level selected by `cfg_trig`: 00 = 1, 01 = 4, 10 = 8, 11 = 14.
- R6: The receiver checks the start bit half a bit time after the falling edge and ignores a low pulse shorter than that. It discards a frame whose stop bit samples low, and it discards a byte that completes while the receive FIFO is full.
- R7: A write of FFh to the command port empties both FIFOs, aborts any frame being sent, and forces `midi_out` high. A write of any other value to the command port has no effect.
- R8: After reset, `midi_out` is 1, `rx_irq` is 0, the status byte reads 80h, and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | ADDR_W | Host access address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid in the strobe cycle |
| cfg_base | input | ADDR_W | Base address of the two-port window |
| cfg_trig | input | 2 | Receive interrupt level select |
| midi_in | input | 1 | Serial input line |
| midi_out | output | 1 | Serial output line |
| rx_irq | output | 1 | Receive-level interrupt |

## Verification
The bench targets the following corner cases:
- **Transmit FIFO full.** The bench overfills the transmit FIFO by one byte. A design that overwrote an entry would send a wrong byte, and one that accepted the extra byte would send an 18th frame.
- **Interrupt thresholds.** The bench steps the receive count across all four thresholds in both directions. A decoder with the wrong encoding, or a latched interrupt, shows up as a wrong `rx_irq` value one byte early or late.
- **Receiver rejection cases.** The bench sends a short low glitch, a frame with a low stop bit, and a 17th byte into a full receive FIFO. A receiver that trusted edges, ignored the stop bit, or wrapped its pointers would hand extra or corrupted bytes to the host.
- **Commands.** An FFh command issued mid-frame must leave the output line high at once. A non-FFh command must leave queued data intact.

// File: rtl/midi_pkg.sv
package midi_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    localparam logic [7:0] CMD_RESET = 8'hFF;

    // interrupt threshold per two-bit select
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/midi_fifo.sv
module midi_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } fifo_s;

    fifo_s s_d, s_q;
    logic  do_push, do_pop;

    assign full  = (s_q.cnt == CNT_W'(DEPTH));
    assign empty = (s_q.cnt == '0);
    assign rdata = s_q.mem[s_q.rp];
    assign count = s_q.cnt;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        do_pop  = pop && !empty;
        do_push = push && (!full || do_pop);
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = wdata;
                s_d.wp          = bump(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = bump(s_q.rp);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + 1'b1;
                2'b01:   s_d.cnt = s_q.cnt - 1'b1;
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2 / R3: occupancy never exceeds the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R6: a push into a full FIFO without a pop leaves the count unchanged
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == $past(count)));

endmodule

// File: rtl/midi_tx.sv
module midi_tx #(
    parameter int BIT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       have_data,
    input  logic [7:0] data,
    output logic       pop,
    output logic       line
);
    localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;

    typedef struct packed {
        logic          busy;
        logic          line;
        logic [8:0]    sh;    // stop bit above the data byte
        logic [3:0]    left;  // bits still to put on the line
        logic [CW-1:0] cnt;
    } tx_s;

    tx_s s_d, s_q;

    assign pop  = !s_q.busy && have_data && !abort;
    assign line = s_q.line;

    always_comb begin
        s_d = s_q;
        if (abort) begin
            s_d.busy = 1'b0;
            s_d.line = 1'b1;
        end else if (!s_q.busy) begin
            s_d.line = 1'b1;
            if (have_data) begin
                s_d.busy = 1'b1;
                s_d.line = 1'b0;
                s_d.sh   = {1'b1, data};
                s_d.left = 4'd9;
                s_d.cnt  = CW'(BIT_CLKS-1);
            end
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end else if (s_q.left == '0) begin
            s_d.busy = 1'b0;
            s_d.line = 1'b1;
        end else begin
            s_d.line = s_q.sh[0];
            s_d.sh   = {1'b0, s_q.sh[8:1]};
            s_d.left = s_q.left - 1'b1;
            s_d.cnt  = CW'(BIT_CLKS-1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    // R2: line rests high whenever no frame is in progress
    a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.busy |-> s_q.line);

    // R7: an abort ends the frame and releases the line
    a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (line && !s_q.busy));

endmodule

// File: rtl/midi_rx.sv
module midi_rx
    import midi_pkg::*;
#(
    parameter int BIT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       abort,
    input  logic       line_in,
    output logic       valid,
    output logic [7:0] data
);
    localparam int CW   = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam int HALF = (BIT_CLKS / 2 > 0) ? BIT_CLKS / 2 : 1;

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [2:0]    n;
        logic [7:0]    sh;
        logic          valid;
        logic [7:0]    data;
    } rx_s;

    rx_s  s_d, s_q;
    logic line_s;

    assign line_s = s_q.sync[1];
    assign valid  = s_q.valid;
    assign data   = s_q.data;

    always_comb begin
        s_d       = s_q;
        s_d.sync  = {s_q.sync[0], line_in};
        s_d.valid = 1'b0;
        if (abort) begin
            s_d.st = RX_IDLE;
        end else begin
            case (s_q.st)
                RX_IDLE: begin
                    if (!line_s) begin
                        s_d.st  = RX_START;
                        s_d.cnt = CW'(HALF-1);
                    end
                end
                RX_START: begin
                    if (s_q.cnt != '0) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end else if (!line_s) begin
                        s_d.st  = RX_DATA;
                        s_d.n   = '0;
                        s_d.cnt = CW'(BIT_CLKS-1);
                    end else begin
                        s_d.st = RX_IDLE;
                    end
                end
                RX_DATA: begin
                    if (s_q.cnt != '0) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end else begin
                        s_d.sh  = {line_s, s_q.sh[7:1]};
                        s_d.n   = s_q.n + 1'b1;
                        s_d.cnt = CW'(BIT_CLKS-1);
                        if (s_q.n == 3'd7) s_d.st = RX_STOP;
                    end
                end
                default: begin
                    if (s_q.cnt != '0) begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end else begin
                        s_d.st = RX_IDLE;
                        if (line_s) begin
                            s_d.valid = 1'b1;
                            s_d.data  = s_q.sh;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
            s_q.st   <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    // R6: a byte is only delivered after a high stop sample
    a_r6_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(line_s));

    // R6: a start that is high again at mid-bit is dropped
    a_r6_glitch_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_START && s_q.cnt == '0 && line_s && !abort)
        |=> (s_q.st == RX_IDLE));

endmodule

// File: rtl/midi_host_port.sv
module midi_host_port
    import midi_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DEPTH      = 16,
    parameter int SAMPLE_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [1:0]        cfg_trig,
    input  logic              midi_in,
    output logic              midi_out,
    output logic              rx_irq
);
    localparam int BIT_CLKS = 16 * SAMPLE_DIV;
    localparam int CNT_W    = $clog2(DEPTH+1);

    logic             sel_data, sel_cmd, cmd_reset;
    logic             tx_push, tx_pop, tx_full, tx_empty;
    logic [7:0]       tx_head;
    logic [CNT_W-1:0] tx_count;
    logic             rx_push, rx_pop, rx_full, rx_empty;
    logic [7:0]       rx_byte, rx_head;
    logic [CNT_W-1:0] rx_count, level;
    logic [7:0]       status;

    assign sel_data  = (host_addr == cfg_base);
    assign sel_cmd   = (host_addr == cfg_base + ADDR_W'(1));
    assign cmd_reset = host_wr && sel_cmd && (host_wdata == CMD_RESET);
    assign tx_push   = host_wr && sel_data;
    assign rx_pop    = host_rd && sel_data;
    assign status    = {rx_empty, tx_full, 6'b0};
    assign level     = CNT_W'(trig_level(cfg_trig));
    assign rx_irq    = (rx_count >= level);

    always_comb begin
        host_rdata = 8'h00;
        if (sel_data && !rx_empty) host_rdata = rx_head;
        else if (sel_cmd)          host_rdata = status;
    end

    midi_fifo #(.DEPTH(DEPTH), .W(8)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_reset),
        .push  (tx_push),
        .wdata (host_wdata),
        .pop   (tx_pop),
        .rdata (tx_head),
        .count (tx_count),
        .full  (tx_full),
        .empty (tx_empty)
    );

    midi_tx #(.BIT_CLKS(BIT_CLKS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (cmd_reset),
        .have_data (!tx_empty),
        .data      (tx_head),
        .pop       (tx_pop),
        .line      (midi_out)
    );

    midi_rx #(.BIT_CLKS(BIT_CLKS)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (cmd_reset),
        .line_in (midi_in),
        .valid   (rx_push),
        .data    (rx_byte)
    );

    midi_fifo #(.DEPTH(DEPTH), .W(8)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .flush (cmd_reset),
        .push  (rx_push),
        .wdata (rx_byte),
        .pop   (rx_pop),
        .rdata (rx_head),
        .count (rx_count),
        .full  (rx_full),
        .empty (rx_empty)
    );

    // R7: the reset command leaves both FIFOs empty and the line high
    a_r7_cmd_flush: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (rx_count == '0 && tx_count == '0 && midi_out));

    // R5: a pop from exactly the threshold count drops the interrupt
    a_r5_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && !rx_empty && rx_count == level)
        |=> (!rx_irq || cfg_trig != $past(cfg_trig)));

    // R5: every threshold lies at or below the depth, so a full FIFO requests
    a_r5_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_irq);

endmodule

// File: tb/midi_host_port_bench.sv
module midi_host_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SDIV       = 4;
    localparam int BITC       = 16 * SDIV;
    localparam logic [15:0] BASE = 16'h0330;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [1:0]  cfg_trig = 2'b00;
    logic        midi_in = 1'b1;
    logic        midi_out, rx_irq;

    int n_tests = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    midi_host_port #(.ADDR_W(16), .DEPTH(16), .SAMPLE_DIV(SDIV)) u_midi_host_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_base(BASE), .cfg_trig(cfg_trig), .midi_in(midi_in),
        .midi_out(midi_out), .rx_irq(rx_irq)
    );

    function automatic int exp_level(input logic [1:0] t);
        case (t)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] exp_status(input int rx_cnt, input bit tx_full);
        return {(rx_cnt == 0), tx_full, 6'b0};
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic host_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        logic [9:0] f;
        f = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            midi_in = f[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk);
        midi_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic capture_tx(output logic [7:0] b, output bit ok);
        wait (midi_out == 1'b0);
        repeat (BITC/2) @(negedge clk);
        ok = (midi_out == 1'b0);
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = midi_out;
        end
        repeat (BITC) @(negedge clk);
        ok = ok && midi_out;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] exp_b [0:31];
        logic [7:0] got_b [0:31];
        bit         ok_b  [0:31];
        int         lows;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8 reset state
        check("R8 midi_out", midi_out, 1);
        check("R8 rx_irq", rx_irq, 0);
        host_read(BASE + 16'd1, rd);
        check("R8 status", rd, 8'h80);
        // R3 empty read
        host_read(BASE, rd);
        check("R3 empty read", rd, 8'h00);

        // R2 random burst
        for (int i = 0; i < 5; i++) exp_b[i] = 8'($urandom);
        fork
            for (int i = 0; i < 5; i++) host_write(BASE, exp_b[i]);
            for (int i = 0; i < 5; i++) capture_tx(got_b[i], ok_b[i]);
        join
        for (int i = 0; i < 5; i++) begin
            check("R2 tx byte", got_b[i], exp_b[i]);
            check("R2 tx framing", ok_b[i], 1);
        end

        // R2/R4 transmit FIFO overfill
        for (int i = 0; i < 18; i++) exp_b[i] = 8'($urandom);
        fork
            begin
                for (int i = 0; i < 18; i++) host_write(BASE, exp_b[i]);
                host_read(BASE + 16'd1, rd);
                check("R4 status tx full", rd, exp_status(0, 1'b1));
            end
            for (int i = 0; i < 17; i++) capture_tx(got_b[i], ok_b[i]);
        join
        for (int i = 0; i < 17; i++) check("R2 full tx byte", got_b[i], exp_b[i]);
        lows = 0;
        repeat (3 * BITC) begin
            @(negedge clk);
            if (!midi_out) lows++;
        end
        check("R2 dropped 18th write", lows, 0);

        // R5/R3 thresholds for every select, random data
        for (int t = 0; t < 4; t++) begin
            int lv;
            cfg_trig = 2'(t);
            lv = exp_level(2'(t));
            for (int i = 0; i < lv; i++) begin
                exp_b[i] = 8'($urandom);
                if (i == lv - 1) check("R5 irq below level", rx_irq, 0);
                send_frame(exp_b[i], 1'b1);
            end
            check("R5 irq at level", rx_irq, 1);
            host_read(BASE + 16'd1, rd);
            check("R4 status rx data", rd, exp_status(lv, 1'b0));
            for (int i = 0; i < lv; i++) begin
                host_read(BASE, rd);
                check("R3 rx byte", rd, exp_b[i]);
                if (i == 0) check("R5 irq clears below level", rx_irq, 0);
            end
            check("R5 irq empty", rx_irq, 0);
        end

        // R6 glitch on the input
        @(negedge clk);
        midi_in = 1'b0;
        repeat (BITC/4) @(negedge clk);
        midi_in = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        host_read(BASE + 16'd1, rd);
        check("R6 glitch ignored", rd, 8'h80);

        // R6 low stop bit
        send_frame(8'h3C, 1'b0);
        repeat (2 * BITC) @(negedge clk);
        host_read(BASE + 16'd1, rd);
        check("R6 bad stop discarded", rd, 8'h80);

        // R6 receive overflow with select 11
        cfg_trig = 2'b11;
        for (int i = 0; i < 17; i++) begin
            exp_b[i] = 8'($urandom);
            send_frame(exp_b[i], 1'b1);
            if (i == 12) check("R5 irq at 13 of 14", rx_irq, 0);
            if (i == 13) check("R5 irq at 14", rx_irq, 1);
        end
        for (int i = 0; i < 16; i++) begin
            host_read(BASE, rd);
            check("R6 overflow keeps first 16", rd, exp_b[i]);
            if (i == 2) check("R5 irq at 13 after reads", rx_irq, 0);
        end
        host_read(BASE, rd);
        check("R6 17th byte dropped", rd, 8'h00);

        // R1 address window
        send_frame(8'hA5, 1'b1);
        host_read(BASE + 16'd2, rd);
        check("R1 outside read", rd, 8'h00);
        host_write(BASE + 16'd2, 8'h55);
        host_write(BASE - 16'd1, 8'hFF);
        lows = 0;
        repeat (2 * BITC) begin
            @(negedge clk);
            if (!midi_out) lows++;
        end
        check("R1 outside write no tx", lows, 0);
        host_read(BASE, rd);
        check("R1 data after outside access", rd, 8'hA5);

        // R7 other command: no effect
        send_frame(8'h81, 1'b1);
        host_write(BASE + 16'd1, 8'h3F);
        host_read(BASE + 16'd1, rd);
        check("R7 other command status", rd, 8'h00);
        host_read(BASE, rd);
        check("R7 other command data", rd, 8'h81);

        // R7 reset command mid-frame
        send_frame(8'h42, 1'b1);
        host_write(BASE, 8'h12);
        host_write(BASE, 8'h34);
        host_write(BASE, 8'h56);
        repeat (3 * BITC) @(negedge clk);
        host_write(BASE + 16'd1, 8'hFF);
        check("R7 line high after reset cmd", midi_out, 1);
        host_read(BASE + 16'd1, rd);
        check("R7 status after reset cmd", rd, 8'h80);
        lows = 0;
        repeat (25 * BITC) begin
            @(negedge clk);
            if (!midi_out) lows++;
        end
        check("R7 tx flushed", lows, 0);
        check("R7 irq after reset cmd", rx_irq, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule